// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character Timeout

This block is the buffering stage between a UART's bit-level receiver and the host. Each cycle the receiver front end may hand it one byte or one break event. In buffered mode the block stores bytes in a 16-entry first-in first-out queue. In unbuffered mode it keeps a single holding register. It keeps the ready, overrun and break status bits, and the host clears them through a data-read strobe and a status-read strobe.

A control write selects buffered or unbuffered mode, chooses one of four fill thresholds, and can flush the queue. A character-time counter raises a timeout flag when data sits unread for four character times. The length of a character comes from the current frame format and the baud divisor. The host uses the threshold flag and the timeout flag to decide when to drain the queue.

Top module: `uart_rx_buffer`

## Requirements
- R1: Control-byte bits 7:6 pick the fill threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In buffered mode `trig_hit` is high while `fill` is at or above the threshold. In unbuffered mode `trig_hit` follows `st_ready`.
- R2: In buffered mode bytes leave in arrival order. `fill` counts the stored bytes. A byte arriving in the same cycle as a host read, on a queue that is neither empty nor full, leaves `fill` unchanged.
- R3: A byte or break arriving while the queue holds 16 bytes is dropped, the stored bytes are kept, and `st_overrun` is set.
- R4: In unbuffered mode (control bit 0 clear) an arriving byte replaces the holding register and sets `st_ready`. If `st_ready` was already set and no host read happens in that cycle, `st_overrun` is also set. A host read clears `st_ready`.
- R5: A host read of an empty queue returns 0 and leaves `fill` at 0. `st_ready` and `st_break` clear when a read empties the queue.
- R6: A break event stores a zero byte and sets both `st_break` and `st_ready`.
- R7: A character time is 1 + (`frame_fmt[1:0]`+5) + `frame_fmt[3]` + (`frame_fmt[2]` ? 2 : 1) bit periods. A bit period is `baud_div`×16 clocks, and a divisor of 0 counts as 1. `tmo_flag` rises exactly four character times of clocks after the last push or pop, provided the queue is non-empty in buffered mode. A host read clears it.
- R8: A control write with bit 1 set, or with bit 0 different from the current mode, empties the queue and clears `st_ready`, `st_break` and the timeout state. In that cycle the flush takes precedence over a simultaneous byte or read.
- R9: A status read clears `st_break` and `st_overrun`. A break or overrun in the same cycle keeps its bit set.
- R10: After reset the block is in unbuffered mode with threshold code 00, `fill` is 0, and all status and flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | A break condition was received this cycle |
| host_rd | input | 1 | Host reads the data register this cycle |
| stat_rd | input | 1 | Host reads the line status this cycle |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: bit0 buffered mode, bit1 flush, bits7:6 threshold |
| frame_fmt | input | 4 | Frame format: [1:0] word length−5, [2] two stop bits, [3] parity |
| baud_div | input | 16 | Baud divisor |
| rd_data | output | 8 | Data presented to a host read |
| fill | output | 5 | Bytes held in the queue |
| trig_hit | output | 1 | Fill threshold reached |
| tmo_flag | output | 1 | Character timeout pending |
| st_ready | output | 1 | Data-ready status |
| st_overrun | output | 1 | Overrun status |
| st_break | output | 1 | Break status |

## Verification
The block must resolve a byte arriving and a host read landing in the same cycle, and a break arriving together with a status read. The bench raises both strobes in one tick for each pair. In the first case it checks that `fill` holds its value and the following reads return bytes in order. In the second it checks that the new break bit survives the clearing read and only goes away on a later status read. Unbuffered mode gets the same treatment: a byte arriving together with a host read must leave `st_ready` set without raising overrun.

// File: rtl/rxb_pkg.sv
// Shared helpers for the UART receive buffer.
// Assumes frame format bits: [1:0] word length minus 5, [2] two stop bits, [3] parity.
package rxb_pkg;

    // Threshold code to byte count.
    function automatic logic [4:0] trig_level(input logic [1:0] code);
        case (code)
            2'b00:   trig_level = 5'd1;
            2'b01:   trig_level = 5'd4;
            2'b10:   trig_level = 5'd8;
            default: trig_level = 5'd14;
        endcase
    endfunction

    // Bits per character: start + data + optional parity + stop bits.
    function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
        frame_bits = 4'd7 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + {3'b000, fmt[2]};
    endfunction

endpackage

// File: rtl/rxb_fifo.sv
// Circular byte queue with an occupancy count.
// Assumes DEPTH is a power of two. The caller gates push when full and pop when empty.
module rxb_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = mem[rd_ptr];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> $stable(count)); // R2
endmodule

// File: rtl/rxb_char_timer.sv
// Character timeout counter. It counts idle clocks while data is waiting and raises
// a flag after CHARS character times. Assumes restart is high on every push or pop.
module rxb_char_timer #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16,
    parameter int CHARS = 4,
    localparam int SCALE = OVS * CHARS,
    localparam int CW    = DIV_W + 4 + $clog2(SCALE) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             clear,
    input  logic [3:0]       fmt,
    input  logic [DIV_W-1:0] divisor,
    output logic             tmo
);
    import rxb_pkg::*;

    logic [DIV_W-1:0] div_eff;
    logic [CW-1:0]    limit;
    logic [CW-1:0]    cnt;

    // Timeout length in clocks for the current frame format.
    always_comb begin
        div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
        limit   = CW'(frame_bits(fmt)) * CW'(div_eff) * CW'(SCALE);
    end

    // Idle counter and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            tmo <= 1'b0;
        end else begin
            if (clear || !enable) tmo <= 1'b0;
            if (restart || !enable) begin
                cnt <= '0;
            end else if (!tmo) begin
                if (cnt >= limit - 1'b1) tmo <= 1'b1;
                else                     cnt <= cnt + 1'b1;
            end
        end
    end

    AST_TMO_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo && restart) |=> !tmo); // R7
endmodule

// File: rtl/uart_rx_buffer.sv
// UART receive buffer: queue or holding register, status bits, threshold and timeout.
// Assumes at most one of rx_valid / rx_break matters per cycle (a break wins).
module uart_rx_buffer #(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16,
    parameter int OVS   = 16,
    parameter int CHARS = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_break,
    input  logic             host_rd,
    input  logic             stat_rd,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    input  logic [3:0]       frame_fmt,
    input  logic [DIV_W-1:0] baud_div,
    output logic [7:0]       rd_data,
    output logic [4:0]       fill,
    output logic             trig_hit,
    output logic             tmo_flag,
    output logic             st_ready,
    output logic             st_overrun,
    output logic             st_break
);
    import rxb_pkg::*;

    logic          fifo_en;
    logic [1:0]    trig_sel;
    logic [7:0]    hold_q;
    logic [7:0]    head;
    logic [CW-1:0] count;
    logic          empty, full;
    logic          flush, rx_evt, push_ok, pop_ok, ovr_q, ovr_h, last_pop;
    logic [7:0]    rx_byte;

    // Event decode for this cycle.
    always_comb begin
        flush    = ctl_wr && (ctl_data[1] || (ctl_data[0] != fifo_en));
        rx_evt   = rx_valid || rx_break;
        rx_byte  = rx_break ? 8'h00 : rx_data;
        push_ok  = rx_evt && fifo_en && !full && !flush;
        pop_ok   = host_rd && fifo_en && !empty && !flush;
        ovr_q    = rx_evt && fifo_en && full && !flush;
        ovr_h    = rx_evt && !fifo_en && st_ready && !host_rd && !flush;
        last_pop = pop_ok && (count == CW'(1)) && !push_ok;
    end

    rxb_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push_ok), .pop(pop_ok),
        .wdata(rx_byte), .head(head), .count(count), .empty(empty), .full(full)
    );

    rxb_char_timer #(.DIV_W(DIV_W), .OVS(OVS), .CHARS(CHARS)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(fifo_en && !empty),
        .restart(push_ok || pop_ok || flush), .clear(pop_ok || flush),
        .fmt(frame_fmt), .divisor(baud_div), .tmo(tmo_flag)
    );

    // Control byte: mode and threshold selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
        end else if (ctl_wr) begin
            fifo_en  <= ctl_data[0];
            trig_sel <= ctl_data[7:6];
        end
    end

    // Unbuffered holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hold_q <= 8'h00;
        else if (rx_evt && !fifo_en && !flush) hold_q <= rx_byte;
    end

    // Data-ready status.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                  st_ready <= 1'b0;
        else if (fifo_en && push_ok)          st_ready <= 1'b1;
        else if (fifo_en && last_pop)         st_ready <= 1'b0;
        else if (!fifo_en && rx_evt)          st_ready <= 1'b1;
        else if (!fifo_en && host_rd)         st_ready <= 1'b0;
    end

    // Break status.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)                  st_break <= 1'b0;
        else if (rx_break)                    st_break <= 1'b1;
        else if (last_pop || stat_rd)         st_break <= 1'b0;
        else if (!fifo_en && host_rd)         st_break <= 1'b0;
    end

    // Overrun status.
    always_ff @(posedge clk) begin
        if (!rst_n)                           st_overrun <= 1'b0;
        else if (ovr_q || ovr_h)              st_overrun <= 1'b1;
        else if (stat_rd)                     st_overrun <= 1'b0;
    end

    assign rd_data  = fifo_en ? (empty ? 8'h00 : head) : hold_q;
    assign fill     = 5'(count);
    assign trig_hit = fifo_en ? (5'(count) >= trig_level(trig_sel)) : st_ready;

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !pop_ok) |=> (st_overrun && $stable(count))); // R3
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == 5'd0 && !st_ready && !st_break && !tmo_flag)); // R8
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_evt) |=> (!st_overrun && !st_break)); // R9
    AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !flush) |=> (st_break && st_ready)); // R6
    AST_TMO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> (fifo_en && fill != 5'd0)); // R7
    AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> !tmo_flag); // R7
endmodule

// File: tb/sim_uart_rx_buffer.sv
// Directed bench for uart_rx_buffer: one task per scenario.
module sim_uart_rx_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_break = 1'b0, host_rd = 1'b0, stat_rd = 1'b0, ctl_wr = 1'b0;
    logic [7:0]  rx_data = 8'h00, ctl_data = 8'h00;
    logic [3:0]  frame_fmt = 4'b0011;
    logic [15:0] baud_div = 16'd1;
    logic [7:0]  rd_data;
    logic [4:0]  fill;
    logic        trig_hit, tmo_flag, st_ready, st_overrun, st_break;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    uart_rx_buffer u0 (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic pop_expect(input string req, input int exp);
        chk(req, rd_data, exp);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_data = v; tick(); ctl_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 fill", fill, 0);
        chk("R10 ready", st_ready, 0);
        chk("R10 overrun", st_overrun, 0);
        chk("R10 break", st_break, 0);
        chk("R10 tmo", tmo_flag, 0);
        chk("R10 trig", trig_hit, 0);
    endtask

    task automatic t_unbuffered();
        push(8'h11);
        chk("R4 ready", st_ready, 1); chk("R4 data", rd_data, 8'h11); chk("R4 no ovr", st_overrun, 0);
        chk("R1 trig follows ready", trig_hit, 1);
        push(8'h22);
        chk("R4 overrun", st_overrun, 1); chk("R4 replaced", rd_data, 8'h22); chk("R4 fill", fill, 0);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R9 ovr cleared", st_overrun, 0);
        rx_valid = 1'b1; rx_data = 8'h33; host_rd = 1'b1; tick(); rx_valid = 1'b0; host_rd = 1'b0;
        chk("R4 read+rx no ovr", st_overrun, 0); chk("R4 read+rx ready", st_ready, 1);
        chk("R4 new data", rd_data, 8'h33);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
        chk("R4 read clears ready", st_ready, 0);
    endtask

    task automatic t_trigger();
        ctl(8'h41);
        chk("R8 enable flush", fill, 0);
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
        chk("R1 below 4", trig_hit, 0); chk("R2 fill3", fill, 3);
        push(8'hA3);
        chk("R1 at 4", trig_hit, 1);
        ctl(8'h81); chk("R1 code10 needs 8", trig_hit, 0); chk("R1 no flush", fill, 4);
        ctl(8'hC1); chk("R1 code11 needs 14", trig_hit, 0);
        ctl(8'h01); chk("R1 code00 needs 1", trig_hit, 1);
        ctl(8'h03); chk("R8 flush fill", fill, 0); chk("R8 flush ready", st_ready, 0);
    endtask

    task automatic t_order();
        push(8'h01); push(8'h02); push(8'h03);
        pop_expect("R2 order 1", 8'h01);
        chk("R2 fill after pop", fill, 2);
        rx_valid = 1'b1; rx_data = 8'h04; host_rd = 1'b1;
        chk("R2 order 2", rd_data, 8'h02);
        tick(); rx_valid = 1'b0; host_rd = 1'b0;
        chk("R2 simultaneous keeps fill", fill, 2);
        pop_expect("R2 order 3", 8'h03);
        pop_expect("R2 order 4", 8'h04);
        chk("R5 empty ready", st_ready, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
        chk("R3 full fill", fill, 16); chk("R3 no ovr yet", st_overrun, 0);
        push(8'hEE);
        chk("R3 overrun", st_overrun, 1); chk("R3 fill kept", fill, 16);
        for (int i = 0; i < 16; i++) pop_expect("R3 contents kept", 8'h10 + i);
        chk("R3 drained", fill, 0);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R9 lsr read clears ovr", st_overrun, 0);
    endtask

    task automatic t_empty_read();
        pop_expect("R5 empty returns 0", 0);
        chk("R5 fill stays 0", fill, 0);
        chk("R5 ready stays 0", st_ready, 0);
    endtask

    task automatic t_break();
        push(8'h55);
        rx_break = 1'b1; tick(); rx_break = 1'b0;
        chk("R6 fill", fill, 2); chk("R6 break", st_break, 1); chk("R6 ready", st_ready, 1);
        pop_expect("R6 first byte", 8'h55);
        chk("R6 break held", st_break, 1);
        pop_expect("R6 zero byte", 8'h00);
        chk("R5 break cleared on empty", st_break, 0); chk("R5 ready cleared", st_ready, 0);
        rx_break = 1'b1; stat_rd = 1'b1; tick(); rx_break = 1'b0; stat_rd = 1'b0;
        chk("R9 set wins", st_break, 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk("R9 break cleared", st_break, 0);
        ctl(8'h03);
        chk("R8 flush clears", fill, 0);
    endtask

    task automatic t_timeout();
        frame_fmt = 4'b0011; baud_div = 16'd1; // 10 bits -> 640 clocks
        push(8'h31); push(8'h32);
        repeat (639) tick();
        chk("R7 not yet", tmo_flag, 0);
        tick();
        chk("R7 fires at 640", tmo_flag, 1);
        pop_expect("R7 read", 8'h31);
        chk("R7 read clears", tmo_flag, 0);
        repeat (639) tick();
        chk("R7 pop restarts", tmo_flag, 0);
        tick();
        chk("R7 fires after pop", tmo_flag, 1);
        frame_fmt = 4'b1100; // 9 bits -> 576 clocks
        pop_expect("R7 drain", 8'h32);
        repeat (700) tick();
        chk("R7 empty never fires", tmo_flag, 0);
        push(8'h33);
        repeat (575) tick();
        chk("R7 9-bit not yet", tmo_flag, 0);
        tick();
        chk("R7 9-bit fires at 576", tmo_flag, 1);
        ctl(8'h03);
        chk("R8 flush clears tmo", tmo_flag, 0);
    endtask

    task automatic t_toggle();
        push(8'h66);
        ctl(8'h00);
        chk("R8 toggle fill", fill, 0); chk("R8 toggle ready", st_ready, 0);
        ctl(8'h01);
        chk("R8 back on empty", fill, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_unbuffered();
        t_trigger();
        t_order();
        t_full();
        t_empty_read();
        t_break();
        t_timeout();
        t_toggle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule